// File: doc/BRIEF.md
# Instruction Address Sequencer with Two-Deep Return Stack

This block produces the fetch address for a small processor core that uses 12-bit instruction words. It holds the program counter. The counter moves only on a per-instruction cycle strobe. When no control is given, it advances by one. It can also load an absolute target, make a subroutine call that saves a return point, or return to the most recently saved point. The decoder drives the controls as plain level signals that qualify the strobe. There is no data stream at this boundary, so there is no valid/ready handshake.

The implemented program memory is either 512 or 1024 words, selected by a static configuration input. Every address the block produces is folded into the implemented space. A counter that runs past the last word therefore wraps to word zero.

In the larger configuration, a page-select bit supplies the address bit above the 9-bit target field. Any taken redirect raises a one-cycle flush request, so the pipeline discards the instruction it has already prefetched.

Top module: `pcu_top`

## Requirements
- R1: While reset is active, and at the first sample after it is released, `fetch_addr` is 0 and `flush` is 0.
- R2: A strobe with no control asserted sets `fetch_addr` to the previous value plus one, folded into the implemented space.
- R3: Without a strobe, `fetch_addr` and the return stack do not change, even if `do_jump`, `do_call` or `do_ret` is high. This is observed through later increments and returns.
- R4: With `mem_large`=0 the address is taken modulo 512, so 511 is followed by 0. With `mem_large`=1 it is taken modulo 1024, so 1023 is followed by 0.
- R5: A strobe with `do_jump` loads `tgt` into address bits 8:0. Bit 9 is `page_sel` when `mem_large`=1 and 0 otherwise. All higher bits are 0.
- R6: A strobe with `do_call` pushes the current `fetch_addr` onto the return stack and loads the target exactly as in R5.
- R7: A strobe with `do_ret` loads the newest stack entry, folded as in R4, and pops it. Two nested calls return in last-in-first-out order.
- R8: The stack holds two entries. A third push discards the oldest entry without any flag. A pop from a drained stack yields whatever the deepest entry still holds.
- R9: `flush` is 1 in the cycle after each strobe that carries a jump, call or return, and 0 in every other cycle.
- R10: When several controls are high on one strobe, return wins over call, and call wins over jump. The losing controls have no effect on the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Instruction cycle strobe; the counter moves only on this |
| mem_large | input | 1 | 0: 512-word memory, 1: 1024-word memory |
| page_sel | input | 1 | Page bit used as address bit 9 in the large configuration |
| tgt | input | 9 | Jump or call target, address bits 8:0 |
| do_jump | input | 1 | Load the target on this strobe |
| do_call | input | 1 | Push the return point and load the target |
| do_ret | input | 1 | Pop the return point into the counter |
| fetch_addr | output | 11 | Current fetch address |
| flush | output | 1 | Discard the prefetched instruction |

## Verification
The bench walks the counter through every word of both memory sizes. A design that wraps at the wrong boundary, or not at all, produces an out-of-range address at word 511 or 1023. Every target value is jumped to under both page bits and both sizes. A design that lets the page bit through in the small configuration lands on the wrong page. Call/return chains three deep, followed by four returns, show whether the oldest entry is dropped and whether the stale deepest entry is reproduced. A design with a deeper stack, or one that clears entries on pop, returns to the wrong place. Strobe-less cycles with controls held high, simultaneous controls, and the cycle after each flush expose a counter that moves without a strobe, a wrong priority, or a flush that lasts too long.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [1:0] {
    SEL_INC = 2'd0,
    SEL_TGT = 2'd1,
    SEL_POP = 2'd2
  } pc_sel_e;

  typedef struct packed {
    logic ret;
    logic call;
    logic jump;
  } pc_ctl_t;

endpackage

// File: rtl/pcu_decide.sv
module pcu_decide
  import pcu_pkg::*;
(
  input  logic    step,
  input  pc_ctl_t ctl,
  output pc_sel_e sel,
  output logic    push,
  output logic    pop,
  output logic    taken
);

  // Priority: return, then call, then jump, then sequential.
  always_comb begin
    sel  = SEL_INC;
    push = 1'b0;
    pop  = 1'b0;
    if (ctl.ret) begin
      sel = SEL_POP;
      pop = step;
    end else if (ctl.call) begin
      sel  = SEL_TGT;
      push = step;
    end else if (ctl.jump) begin
      sel = SEL_TGT;
    end
  end

  assign taken = step & (ctl.ret | ctl.call | ctl.jump);

endmodule

// File: rtl/pcu_stack.sv
module pcu_stack #(
  parameter int AW    = 11,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] top
);

  logic [AW-1:0] ent [DEPTH];

  assign top = ent[0];

  // Push shifts toward the deep end and drops the oldest entry.
  // Pop shifts toward the top; the deepest entry keeps its value.
  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    if (i == 0) begin : g_top
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          ent[i] <= '0;
        else if (push)
          ent[i] <= din;
        else if (pop && DEPTH > 1)
          ent[i] <= ent[(DEPTH > 1) ? 1 : 0];
      end
    end else if (i == DEPTH - 1) begin : g_deep
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          ent[i] <= '0;
        else if (push)
          ent[i] <= ent[i-1];
      end
    end else begin : g_mid
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          ent[i] <= '0;
        else if (push)
          ent[i] <= ent[i-1];
        else if (pop)
          ent[i] <= ent[i+1];
      end
    end
  end

endmodule

// File: rtl/pcu_next.sv
module pcu_next
  import pcu_pkg::*;
#(
  parameter int PC_W     = 11,
  parameter int SMALL_AW = 9
) (
  input  logic [PC_W-1:0]     pc,
  input  pc_sel_e             sel,
  input  logic [SMALL_AW-1:0] tgt,
  input  logic                page_sel,
  input  logic                mem_large,
  input  logic [PC_W-1:0]     top,
  output logic [PC_W-1:0]     nxt
);

  localparam int LARGE_AW = SMALL_AW + 1;
  localparam logic [PC_W-1:0] SMALL_MASK = PC_W'((1 << SMALL_AW) - 1);
  localparam logic [PC_W-1:0] LARGE_MASK = PC_W'((1 << LARGE_AW) - 1);

  logic [PC_W-1:0] mask;
  logic [PC_W-1:0] jt;
  logic [PC_W-1:0] raw;

  assign mask = mem_large ? LARGE_MASK : SMALL_MASK;
  assign jt   = {{(PC_W - LARGE_AW){1'b0}}, page_sel & mem_large, tgt};

  always_comb begin
    case (sel)
      SEL_TGT: raw = jt;
      SEL_POP: raw = top;
      default: raw = pc + PC_W'(1);
    endcase
  end

  assign nxt = raw & mask;

endmodule

// File: rtl/pcu_top.sv
module pcu_top
  import pcu_pkg::*;
#(
  parameter int PC_W     = 11,
  parameter int SMALL_AW = 9,
  parameter int DEPTH    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                mem_large,
  input  logic                page_sel,
  input  logic [SMALL_AW-1:0] tgt,
  input  logic                do_jump,
  input  logic                do_call,
  input  logic                do_ret,
  output logic [PC_W-1:0]     fetch_addr,
  output logic                flush
);

  pc_ctl_t         ctl;
  pc_sel_e         sel;
  logic            push;
  logic            pop;
  logic            taken;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] nxt;
  logic [PC_W-1:0] top;

  assign ctl = '{ret: do_ret, call: do_call, jump: do_jump};

  pcu_decide u_decide (
    .step  (step),
    .ctl   (ctl),
    .sel   (sel),
    .push  (push),
    .pop   (pop),
    .taken (taken)
  );

  pcu_stack #(.AW(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .din   (pc_q),
    .top   (top)
  );

  pcu_next #(.PC_W(PC_W), .SMALL_AW(SMALL_AW)) u_next (
    .pc        (pc_q),
    .sel       (sel),
    .tgt       (tgt),
    .page_sel  (page_sel),
    .mem_large (mem_large),
    .top       (top),
    .nxt       (nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      flush <= 1'b0;
    end else begin
      flush <= taken;
      if (step)
        pc_q <= nxt;
    end
  end

  assign fetch_addr = pc_q;

endmodule

// File: rtl/pcu_chk.sv
module pcu_chk #(
  parameter int PC_W     = 11,
  parameter int SMALL_AW = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic                step,
  input logic                mem_large,
  input logic                page_sel,
  input logic [SMALL_AW-1:0] tgt,
  input logic                do_jump,
  input logic                do_call,
  input logic                do_ret,
  input logic [PC_W-1:0]     fetch_addr,
  input logic                flush
);

  logic            any_ctl;
  logic [PC_W-1:0] ck_mask;
  logic [PC_W-1:0] ck_jt;

  assign any_ctl = do_jump | do_call | do_ret;
  assign ck_mask = mem_large ? PC_W'((1 << (SMALL_AW + 1)) - 1)
                             : PC_W'((1 << SMALL_AW) - 1);
  assign ck_jt   = PC_W'({(page_sel & mem_large), tgt});

  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(fetch_addr)); // R3

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !any_ctl) |=> fetch_addr == (($past(fetch_addr) + PC_W'(1)) & $past(ck_mask))); // R2

  AST_SMALL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !mem_large) |=> (fetch_addr >> SMALL_AW) == '0); // R4

  AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && do_jump && !do_call && !do_ret) |=> fetch_addr == $past(ck_jt)); // R5

  AST_FLUSH_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && any_ctl) |=> flush); // R9

  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(step && any_ctl) |=> !flush); // R9

endmodule

bind pcu_top pcu_chk #(.PC_W(PC_W), .SMALL_AW(SMALL_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step       (step),
  .mem_large  (mem_large),
  .page_sel   (page_sel),
  .tgt        (tgt),
  .do_jump    (do_jump),
  .do_call    (do_call),
  .do_ret     (do_ret),
  .fetch_addr (fetch_addr),
  .flush      (flush)
);

// File: tb/pcu_top_tb.sv
module pcu_top_tb;

  localparam int PC_W = 11;
  localparam int SAW  = 9;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            step = 1'b0;
  logic            mem_large = 1'b0;
  logic            page_sel = 1'b0;
  logic [SAW-1:0]  tgt = '0;
  logic            do_jump = 1'b0;
  logic            do_call = 1'b0;
  logic            do_ret = 1'b0;
  logic [PC_W-1:0] fetch_addr;
  logic            flush;

  int total = 0;
  int bad = 0;
  int exp_pc = 0;
  int s1 = 0;
  int s2 = 0;

  always #10 clk = ~clk;

  pcu_top #(.PC_W(PC_W), .SMALL_AW(SAW), .DEPTH(2)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .mem_large  (mem_large),
    .page_sel   (page_sel),
    .tgt        (tgt),
    .do_jump    (do_jump),
    .do_call    (do_call),
    .do_ret     (do_ret),
    .fetch_addr (fetch_addr),
    .flush      (flush)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One gap cycle with no strobe, then one cycle carrying the given controls.
  task automatic cyc(input string tag, input bit st, input bit j, input bit c,
                     input bit r, input int t, input bit p);
    int mask;
    int np;
    bit taken;
    @(negedge clk);
    check("R3 idle addr", int'(fetch_addr), exp_pc);
    check("R9 flush low", int'(flush), 0);
    step = st; do_jump = j; do_call = c; do_ret = r;
    tgt = SAW'(t); page_sel = p;
    mask  = mem_large ? 1023 : 511;
    taken = st && (j || c || r);
    np = exp_pc;
    if (st) begin
      if (r) begin
        np = s1 & mask; s1 = s2;
      end else if (c) begin
        s2 = s1; s1 = exp_pc;
        np = ((mem_large && p) ? 512 : 0) + t;
      end else if (j) begin
        np = ((mem_large && p) ? 512 : 0) + t;
      end else begin
        np = (exp_pc + 1) & mask;
      end
    end
    @(negedge clk);
    exp_pc = np;
    check(tag, int'(fetch_addr), exp_pc);
    check("R9 flush", int'(flush), taken ? 1 : 0);
    step = 0; do_jump = 0; do_call = 0; do_ret = 0;
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    #5;
    check("R1 reset addr", int'(fetch_addr), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 addr after release", int'(fetch_addr), 0);
    check("R1 flush after release", int'(flush), 0);

    // R2/R4: full sweep of the small space, wrap 511 -> 0
    mem_large = 1'b0;
    for (int i = 0; i < 512; i++) cyc("R2 R4 small inc", 1, 0, 0, 0, 0, 0);
    check("R4 small wrap", exp_pc, 0);

    // R2/R4: full sweep of the large space, wrap 1023 -> 0
    mem_large = 1'b1;
    for (int i = 0; i < 1024; i++) cyc("R2 R4 large inc", 1, 0, 0, 0, 0, 0);
    check("R4 large wrap", exp_pc, 0);

    // R5: every target under both sizes and both page bits
    for (int l = 0; l < 2; l++) begin
      mem_large = l[0];
      for (int p = 0; p < 2; p++)
        for (int t = 0; t < 512; t++) cyc("R5 jump", 1, 1, 0, 0, t, p[0]);
    end

    // R3: controls without strobe are ignored
    mem_large = 1'b1;
    cyc("R5 setup", 1, 1, 0, 0, 9'h040, 1);
    cyc("R3 jump no strobe", 0, 1, 0, 0, 9'h1AA, 0);
    cyc("R3 call no strobe", 0, 0, 1, 0, 9'h0AA, 0);
    cyc("R3 ret no strobe", 0, 0, 0, 1, 0, 0);

    // R6/R7: nested calls return in LIFO order
    cyc("R6 call 1", 1, 0, 1, 0, 9'h100, 0);
    cyc("R2 step in sub", 1, 0, 0, 0, 0, 0);
    cyc("R6 call 2", 1, 0, 1, 0, 9'h020, 1);
    cyc("R7 ret inner", 1, 0, 0, 1, 0, 0);
    cyc("R7 ret outer", 1, 0, 0, 1, 0, 0);
    check("R7 outer returns to 0x240", exp_pc, 12'h240);

    // R8: three pushes, four pops
    cyc("R5 setup", 1, 1, 0, 0, 9'h011, 0);
    cyc("R8 call a", 1, 0, 1, 0, 9'h022, 0);
    cyc("R8 call b", 1, 0, 1, 0, 9'h033, 1);
    cyc("R8 call c", 1, 0, 1, 0, 9'h044, 0);
    cyc("R8 pop 1", 1, 0, 0, 1, 0, 0);
    check("R8 pop1 value", exp_pc, 12'h233);
    cyc("R8 pop 2", 1, 0, 0, 1, 0, 0);
    check("R8 pop2 value", exp_pc, 12'h022);
    cyc("R8 pop stale 3", 1, 0, 0, 1, 0, 0);
    check("R8 stale value", exp_pc, 12'h022);
    cyc("R8 pop stale 4", 1, 0, 0, 1, 0, 0);

    // R10: priority among simultaneous controls
    cyc("R5 setup", 1, 1, 0, 0, 9'h070, 0);
    cyc("R10 call beats jump", 1, 1, 1, 0, 9'h0F0, 0);
    cyc("R10 ret beats call+jump", 1, 1, 1, 1, 9'h1F0, 1);
    check("R10 returned to 0x070", exp_pc, 12'h070);
    cyc("R10 ret beats jump", 1, 1, 0, 1, 9'h155, 0);

    // R4/R7: popped value folded into the small space
    cyc("R5 setup", 1, 1, 0, 0, 9'h1FE, 1);
    cyc("R6 call high page", 1, 0, 1, 0, 9'h003, 0);
    mem_large = 1'b0;
    cyc("R4 R7 folded pop", 1, 0, 0, 1, 0, 0);
    check("R4 folded value", exp_pc, 12'h1FE);
    cyc("R4 step to 511 wrap", 1, 0, 0, 0, 0, 0);
    cyc("R4 wrap after pop", 1, 0, 0, 0, 0, 0);

    @(negedge clk);
    check("R9 final flush low", int'(flush), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule